// File: doc/BRIEF.md
# SPI Command Frame Builder

This block sits on the host side of a byte-wide SPI link to a peripheral that takes framed commands. A request gives an opcode, an address, a transfer length or a write word, a clockless-mode flag and a CRC7 enable. The block sends the frame one byte at a time through a strobe handshake that stands in for the bit shifter. It then sends filler bytes to clock in a two-byte reply, an echo of the opcode followed by a status byte. The request ends with a one-cycle `done` when the reply is good, or a one-cycle `error` when it is not.

Each opcode has its own frame layout. Addresses are two or three bytes long and lengths are two or three bytes long. Internal accesses can carry a clockless flag in the top bit of the address. An optional CRC7 trailer covers every byte that comes before it. Data-phase transfers are handled elsewhere.

Top module: `spi_cmd_framer`

## Requirements
- R1: Opcodes 0xCA (single read) and 0xCF (reset) send the opcode, then address bits 23:16, 15:8 and 7:0, in that order.
- R2: Opcode 0xC9 (single write) sends the opcode, the 3 address bytes (most significant first), then the 32-bit write word, most significant byte first.
- R3: Opcode 0xC3 (internal write) sends the opcode, address byte 15:8 with bit 7 forced to 1 when the clockless flag is set, address byte 7:0, then the 32-bit write word, most significant byte first.
- R4: Opcode 0xC4 (internal read) sends the opcode, the two address bytes with the same clockless rule as R3, then one 0x00 pad byte.
- R5: Opcodes 0xC1 and 0xC2 send the opcode, 3 address bytes and length bits 15:0 (2 bytes). Opcodes 0xC7 and 0xC8 send the opcode, 3 address bytes and length bits 23:0 (3 bytes). All fields go most significant byte first.
- R6: When CRC is enabled, one trailer byte follows the frame. Its bits 7:1 hold the CRC7 of every preceding frame byte, using polynomial x^7+x^3+1, a register preset to all ones, and bytes fed MSB first. Its bit 0 is 0. When CRC is disabled, no trailer is sent.
- R7: After the frame, exactly two filler bytes of value 0x00 are sent. The received byte that arrives with the first filler is taken as the echo, and the byte with the second is taken as the status.
- R8: After the second reply byte, `done` pulses for one cycle if the echo equals the opcode and the status is 0x00. Otherwise `error` pulses for one cycle. The two never pulse together.
- R9: An opcode outside the list above raises `error` in the cycle after the request is accepted, and no byte is sent.
- R10: `req_ready` is high only while the block is idle and not pulsing `done` or `error`. A request offered while `req_ready` is low changes neither the frame in flight nor its outcome.
- R11: After reset, `req_ready` is 1 and `tx_valid`, `done` and `error` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_opcode | input | 8 | Command opcode |
| req_addr | input | 24 | Target address |
| req_len | input | 24 | Transfer length for DMA opcodes |
| req_wdata | input | 32 | Write word for write opcodes |
| req_clockless | input | 1 | Set bit 7 of the first address byte on internal opcodes |
| req_crc_en | input | 1 | Append CRC7 trailer |
| tx_valid | output | 1 | A byte is waiting to be shifted |
| tx_byte | output | 8 | Byte to shift out |
| tx_ack | input | 1 | Shifter strobe: byte sent, rx_byte valid this cycle |
| rx_byte | input | 8 | Byte shifted in alongside the acknowledged byte |
| done | output | 1 | One-cycle pulse: reply good |
| error | output | 1 | One-cycle pulse: reply bad or opcode unsupported |

## Verification
The bench builds the block with its default parameters: filler 0x00, CRC seed all ones and an 8-byte frame store. These defaults reach every layout, including the longest frame, single write with the trailer (9 bytes). The scoreboard predicts each byte from the layout rules and the CRC7 definition. It covers both clockless settings, an address whose top bit is already set, back-to-back and gapped shifter strobes, bad echo and bad status replies, an unsupported opcode, and a request offered while the block is busy.

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer #(
  parameter logic [7:0] FILL_BYTE = 8'h00,
  parameter logic [6:0] CRC_SEED  = 7'h7F,
  parameter int         FRAME_MAX = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_opcode,
  input  logic [23:0] req_addr,
  input  logic [23:0] req_len,
  input  logic [31:0] req_wdata,
  input  logic        req_clockless,
  input  logic        req_crc_en,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  input  logic        tx_ack,
  input  logic [7:0]  rx_byte,
  output logic        done,
  output logic        error
);
  localparam int FW = FRAME_MAX * 8;
  localparam int CW = $clog2(FRAME_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_CRC, S_RSP} state_t;

  state_t          state;
  logic [FW-1:0]   frame, ld_frame;
  logic [CW-1:0]   left, ld_len;
  logic            ld_bad, crc_on, rsp_idx;
  logic [6:0]      crc;
  logic [7:0]      op_q, echo_q, addr_hi;

  function automatic logic [6:0] crc_step(input logic [6:0] c, input logic [7:0] b);
    logic [6:0] r;
    logic       fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[6] ^ b[i];
      r  = {r[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return r;
  endfunction

  assign addr_hi = req_addr[15:8] | {req_clockless, 7'b0};

  always_comb begin
    ld_frame = '0;
    ld_len   = '0;
    ld_bad   = 1'b0;
    case (req_opcode)
      8'hCA, 8'hCF: begin
        ld_frame[FW-1 -: 32] = {req_opcode, req_addr};
        ld_len = CW'(4);
      end
      8'hC9: begin
        ld_frame[FW-1 -: 64] = {req_opcode, req_addr, req_wdata};
        ld_len = CW'(8);
      end
      8'hC3: begin
        ld_frame[FW-1 -: 56] = {req_opcode, addr_hi, req_addr[7:0], req_wdata};
        ld_len = CW'(7);
      end
      8'hC4: begin
        ld_frame[FW-1 -: 32] = {req_opcode, addr_hi, req_addr[7:0], 8'h00};
        ld_len = CW'(4);
      end
      8'hC1, 8'hC2: begin
        ld_frame[FW-1 -: 48] = {req_opcode, req_addr, req_len[15:0]};
        ld_len = CW'(6);
      end
      8'hC7, 8'hC8: begin
        ld_frame[FW-1 -: 56] = {req_opcode, req_addr, req_len};
        ld_len = CW'(7);
      end
      default: ld_bad = 1'b1;
    endcase
  end

  assign req_ready = (state == S_IDLE) && !done && !error;
  assign tx_valid  = (state != S_IDLE);

  always_comb begin
    case (state)
      S_CMD:   tx_byte = frame[FW-1 -: 8];
      S_CRC:   tx_byte = {crc, 1'b0};
      S_RSP:   tx_byte = FILL_BYTE;
      default: tx_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      frame   <= '0;
      left    <= '0;
      crc     <= CRC_SEED;
      crc_on  <= 1'b0;
      rsp_idx <= 1'b0;
      op_q    <= 8'h00;
      echo_q  <= 8'h00;
      done    <= 1'b0;
      error   <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (state)
        S_IDLE: if (req_valid && req_ready) begin
          if (ld_bad) begin
            error <= 1'b1;
          end else begin
            state   <= S_CMD;
            frame   <= ld_frame;
            left    <= ld_len;
            crc     <= CRC_SEED;
            crc_on  <= req_crc_en;
            op_q    <= req_opcode;
            rsp_idx <= 1'b0;
          end
        end
        S_CMD: if (tx_ack) begin
          frame <= frame << 8;
          crc   <= crc_step(crc, tx_byte);
          left  <= left - 1'b1;
          if (left == CW'(1)) state <= crc_on ? S_CRC : S_RSP;
        end
        S_CRC: if (tx_ack) state <= S_RSP;
        S_RSP: if (tx_ack) begin
          if (!rsp_idx) begin
            echo_q  <= rx_byte;
            rsp_idx <= 1'b1;
          end else begin
            done  <= (echo_q == op_q) && (rx_byte == 8'h00);
            error <= !((echo_q == op_q) && (rx_byte == 8'h00));
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  assert_outcome_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |=> !(done || error) || $past(req_valid));
  assert_reply_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RSP && tx_ack && rsp_idx) |=> (done || error) && !tx_valid);
  assert_bad_opcode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ld_bad) |=> error && !tx_valid);
  assert_busy_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !req_ready);
  assert_byte_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ack) |=> tx_valid && $stable(tx_byte));
endmodule

// File: tb/test_spi_cmd_framer.sv
module test_spi_cmd_framer;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_clockless = 1'b0, req_crc_en = 1'b0;
  logic [7:0]  req_opcode = 8'h00;
  logic [23:0] req_addr = '0, req_len = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, tx_valid, done, error;
  logic [7:0]  tx_byte;
  logic        tx_ack = 1'b0;
  logic [7:0]  rx_byte = 8'h00;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       out_q[$];
  string      out_tag[$];
  int  bidx = 0, cur_len = 0;
  logic [7:0] cur_echo = 0, cur_status = 0;
  logic slow = 1'b0, phase = 1'b0;

  always #2 clk = ~clk;

  spi_cmd_framer i_spi_cmd_framer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .req_clockless(req_clockless), .req_crc_en(req_crc_en),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ack(tx_ack), .rx_byte(rx_byte),
    .done(done), .error(error));

  function automatic logic [7:0] crc_byte(input logic [7:0] c8, input logic [7:0] b);
    logic [7:0] r = c8;
    for (int i = 0; i < 8; i++) begin
      if (((r ^ (b << i)) & 8'h80) != 0) r = (r << 1) ^ 8'h12;
      else r = r << 1;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // monitor: acts as the shifter and scoreboard
  initial forever begin
    @(negedge clk);
    tx_ack = 1'b0;
    if (done || error) begin
      check(!(done && error), "R8 done and error together", {done, error}, 2'b01);
      if (out_q.size() == 0) check(0, "R8 unexpected outcome", {done, error}, 0);
      else begin
        automatic logic e = out_q.pop_front();
        automatic string t = out_tag.pop_front();
        check(done == e && error == !e, t, {done, error}, {e, !e});
        check(exp_q.size() == 0, "R7 frame length", exp_q.size(), 0);
      end
    end
    if (tx_valid && (!slow || phase)) begin
      if (exp_q.size() == 0) check(0, "R9 unexpected byte", tx_byte, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(tx_byte == e, t, tx_byte, e);
      end
      rx_byte = (bidx == cur_len) ? cur_echo : (bidx == cur_len + 1) ? cur_status : 8'hFF;
      bidx++;
      tx_ack = 1'b1;
    end
    phase = ~phase;
  end

  initial forever begin
    @(posedge clk);
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic push(input logic [7:0] b, input string t);
    exp_q.push_back(b); tag_q.push_back(t);
  endtask

  task automatic run(input logic [7:0] op, input logic [23:0] a, input logic [23:0] ln,
                     input logic [31:0] wd, input bit ckl, input bit crc_en,
                     input bit good_echo, input logic [7:0] status, input bit poke, input string t);
    logic [7:0] fr[$];
    logic [7:0] c8;
    bit bad = 0;
    case (op)
      8'hCA, 8'hCF: fr = '{op, a[23:16], a[15:8], a[7:0]};
      8'hC9: fr = '{op, a[23:16], a[15:8], a[7:0], wd[31:24], wd[23:16], wd[15:8], wd[7:0]};
      8'hC3: fr = '{op, a[15:8] | {ckl, 7'b0}, a[7:0], wd[31:24], wd[23:16], wd[15:8], wd[7:0]};
      8'hC4: fr = '{op, a[15:8] | {ckl, 7'b0}, a[7:0], 8'h00};
      8'hC1, 8'hC2: fr = '{op, a[23:16], a[15:8], a[7:0], ln[15:8], ln[7:0]};
      8'hC7, 8'hC8: fr = '{op, a[23:16], a[15:8], a[7:0], ln[23:16], ln[15:8], ln[7:0]};
      default: bad = 1;
    endcase
    if (!bad) begin
      c8 = 8'hFE;
      foreach (fr[i]) begin c8 = crc_byte(c8, fr[i]); push(fr[i], t); end
      if (crc_en) push(c8, "R6 CRC7 trailer");
      push(8'h00, "R7 filler 1");
      push(8'h00, "R7 filler 2");
    end
    cur_len = fr.size() + (crc_en ? 1 : 0);
    cur_echo = good_echo ? op : (op ^ 8'h40);
    cur_status = status;
    bidx = 0;
    out_q.push_back(!bad && good_echo && status == 0);
    out_tag.push_back(bad ? "R9 unsupported opcode" : "R8 outcome");
    @(negedge clk);
    check(req_ready, "R10 ready when idle", req_ready, 1);
    req_opcode = op; req_addr = a; req_len = ln; req_wdata = wd;
    req_clockless = ckl; req_crc_en = crc_en; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      @(negedge clk);
      check(!req_ready, "R10 ready low while busy", req_ready, 0);
      req_opcode = 8'hCA; req_addr = 24'hFFFFFF; req_crc_en = ~crc_en; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (out_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1;
    check(req_ready === 1'b1 && tx_valid === 1'b0 && done === 1'b0 && error === 1'b0,
          "R11 reset state", {req_ready, tx_valid, done, error}, 4'b1000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !tx_valid && !done && !error, "R11 after reset",
          {req_ready, tx_valid, done, error}, 4'b1000);
    run(8'hCA, 24'h123456, 0, 0, 0, 0, 1, 8'h00, 0, "R1 single read");
    slow = 1;
    run(8'hC9, 24'hA1B2C3, 0, 32'hDEADBEEF, 0, 1, 1, 8'h00, 0, "R2 single write");
    slow = 0;
    run(8'hC3, 24'h000123, 0, 32'h01020304, 1, 0, 1, 8'h00, 0, "R3 internal write clockless");
    run(8'hC3, 24'h00F0AA, 0, 32'hCAFEF00D, 0, 1, 1, 8'h00, 0, "R3 internal write");
    run(8'hC4, 24'h0080AB, 0, 0, 0, 1, 1, 8'h00, 0, "R4 internal read");
    run(8'hC4, 24'h001122, 0, 0, 1, 0, 1, 8'h00, 0, "R4 internal read clockless");
    run(8'hC1, 24'h300000, 24'h123456, 0, 0, 0, 1, 8'h00, 0, "R5 DMA write");
    run(8'hC2, 24'h000010, 24'h0000FF, 0, 0, 1, 1, 8'h00, 0, "R5 DMA read");
    slow = 1;
    run(8'hC8, 24'h445566, 24'hABCDEF, 0, 0, 1, 1, 8'h00, 0, "R5 ext DMA read");
    slow = 0;
    run(8'hC7, 24'h010203, 24'h040506, 0, 0, 0, 1, 8'h00, 0, "R5 ext DMA write");
    run(8'hCF, 24'hFFFFFF, 0, 0, 0, 1, 1, 8'h00, 0, "R1 reset command");
    run(8'hCA, 24'h000004, 0, 0, 0, 0, 0, 8'h00, 0, "R8 echo mismatch");
    run(8'hC9, 24'h000008, 0, 32'h5, 0, 1, 1, 8'h01, 0, "R8 status nonzero");
    run(8'hC5, 24'h000000, 0, 0, 0, 1, 1, 8'h00, 0, "R9 bad opcode");
    run(8'hC9, 24'h0A0B0C, 0, 32'h11223344, 0, 1, 1, 8'h00, 1, "R10 busy request ignored");
    run(8'hCA, 24'h00BEEF, 0, 0, 0, 1, 1, 8'h00, 0, "R10 next request");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule